// File: doc/BRIEF.md
# Locked-Rotor Protection Supervisor

This block is the control and safety sequencer that sits beside a motor's speed loop. It takes a start/stop request, a braking-style select, the lock flag from the speed loop, a one-cycle pulse per reference-clock edge and a flag that says the motor is slowing after a change of reference frequency. From these it drives a drive enable, a low-side kill, a reverse-torque braking select and a power-save signal.

At power-up the block first produces its own reset interval. It then waits in a stopped, power-saving state until a start is requested. While running, it times how long the speed loop stays unlocked. If that time runs out, it latches a fault that removes low-side drive. The fault is held until a stop is requested or power is removed, and the return of lock does not clear it.

The block also watches the reference clock. A missing reference is counted as unlocked, so a lost clock trips the same protection. This stops a motor under reverse-torque braking from being driven faster and faster in reverse. The unlocked timer is kept at zero during the slow-down that follows a frequency change.

Top module: `rotor_guard`

## Requirements
- R1: After `rst_n` is released, the block stays in its reset phase for `POR_CYCLES` clock edges and then enters the stopped state. Throughout the reset phase `drive_en`=0, `lowside_kill`=1, `power_save`=1 and `brake_rev`=0.
- R2: `start_n`=0 requests run and `start_n`=1 requests stop, so a pad pulled high when undriven means stop. A run request in the stopped state enters the running state on the next edge. A stop request in any state other than the reset phase returns to the stopped state on the next edge.
- R3: `power_save` is 1 exactly in the stopped state and the reset phase, and it is never 1 while `drive_en` is 1.
- R4: Outside the reset phase, `brake_rev` takes the value of `~coast_sel` on each clock edge (one cycle of latency). 0 means free-running coast and 1 means reverse torque.
- R5: In the running state, `TRIP_CYCLES` consecutive cycles with the loop unlocked move the block to the fault state. In the fault state `drive_en`=0 and `lowside_kill`=1. `drive_en` and `lowside_kill` are never both 1.
- R6: A return to lock in the running state before `TRIP_CYCLES` unlocked cycles have passed restarts the unlocked count from zero, and no fault results.
- R7: The fault state persists while `start_n`=0, even with lock restored. Only a stop request (or reset) leaves it, and it leaves to the stopped state.
- R8: `decel`=1 in the running state moves the block to a slow-down state in which drive stays enabled and the unlocked count is held at zero. `decel`=0 returns it to the running state.
- R9: `clk_lost` rises after `CLK_TIMEOUT` clock edges with no `ref_edge` pulse, and it clears on the edge that samples a `ref_edge` pulse.
- R10: While `clk_lost`=1, the running state counts the cycle as unlocked even when `locked`=1, so a lost reference trips the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| start_n | input | 1 | 0 = run request, 1 = stop request |
| coast_sel | input | 1 | 1 = coast when braking, 0 = reverse torque |
| locked | input | 1 | Speed loop lock flag, 1 = locked |
| ref_edge | input | 1 | One-cycle pulse per reference clock edge |
| decel | input | 1 | Slow-down after reference frequency change |
| drive_en | output | 1 | Motor drive enabled |
| lowside_kill | output | 1 | Low-side drive forced off |
| brake_rev | output | 1 | Reverse-torque braking selected |
| power_save | output | 1 | Bias removal request in stop |
| clk_lost | output | 1 | Reference clock absent beyond the timeout |

## Verification
Directed sequences test the unlock timer with three kinds of unlocked burst. A burst shorter than the trip window tells a restarting counter from an accumulating one. A burst longer than the window tells a correct trip point from a late or missing one. An unlocked burst during slow-down tells a suppressed timer from a free-running one. A stalled reference with lock held high tells whether clock loss feeds the protection path, and a return of lock while faulted tells a latched fault from a self-clearing one. Long random sequences then toggle start, lock, slow-down, brake select and reference gaps, and a cycle model checks every output on every cycle.

// File: rtl/rg_pkg.sv
package rg_pkg;
    typedef enum logic [2:0] {
        ST_RESET = 3'd0,
        ST_STOP  = 3'd1,
        ST_RUN   = 3'd2,
        ST_DECEL = 3'd3,
        ST_FAULT = 3'd4
    } rg_state_e;

    typedef struct packed {
        rg_state_e state;
        logic      brake_rev;
    } rg_ctl_t;
endpackage

// File: rtl/rg_por.sv
module rg_por #(
    parameter int POR_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(POR_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == LAST);

    // R1
    por_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
endmodule

// File: rtl/rg_refwatch.sv
module rg_refwatch #(
    parameter int CLK_TIMEOUT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ref_edge,
    output logic lost
);
    localparam int CW = $clog2(CLK_TIMEOUT);
    localparam logic [CW-1:0] LAST = CW'(CLK_TIMEOUT - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          lost_d, lost_q;

    always_comb begin
        cnt_d  = cnt_q;
        lost_d = lost_q;
        if (hold || ref_edge) begin
            cnt_d  = '0;
            lost_d = 1'b0;
        end else if (cnt_q == LAST) begin
            lost_d = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lost_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            lost_q <= lost_d;
        end
    end

    assign lost = lost_q;

    // R9
    edge_clears_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> !lost);
    // R9
    lost_needs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lost) |-> $past(cnt_q) == LAST);
endmodule

// File: rtl/rg_unlock_timer.sv
module rg_unlock_timer #(
    parameter int TRIP_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic bad,
    output logic trip
);
    localparam int CW = $clog2(TRIP_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(TRIP_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (arm && bad) cnt_d = (cnt_q == LAST) ? cnt_q : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign trip = arm && bad && (cnt_q == LAST);

    // R5
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // R6
    relock_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bad |=> cnt_q == '0);
endmodule

// File: rtl/rotor_guard.sv
module rotor_guard
    import rg_pkg::*;
#(
    parameter int POR_CYCLES  = 64,
    parameter int TRIP_CYCLES = 1000,
    parameter int CLK_TIMEOUT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_n,
    input  logic coast_sel,
    input  logic locked,
    input  logic ref_edge,
    input  logic decel,
    output logic drive_en,
    output logic lowside_kill,
    output logic brake_rev,
    output logic power_save,
    output logic clk_lost
);
    rg_ctl_t ctl_d, ctl_q;
    logic    por_done, lost, trip, in_reset, in_run, bad;

    assign in_reset = (ctl_q.state == ST_RESET);
    assign in_run   = (ctl_q.state == ST_RUN);
    assign bad      = !locked || lost;

    rg_por #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk(clk), .rst_n(rst_n), .done(por_done));

    rg_refwatch #(.CLK_TIMEOUT(CLK_TIMEOUT)) u_ref (
        .clk(clk), .rst_n(rst_n), .hold(in_reset), .ref_edge(ref_edge), .lost(lost));

    rg_unlock_timer #(.TRIP_CYCLES(TRIP_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .arm(in_run), .bad(bad), .trip(trip));

    always_comb begin
        ctl_d = ctl_q;
        ctl_d.brake_rev = in_reset ? 1'b0 : ~coast_sel;
        unique case (ctl_q.state)
            ST_RESET: if (por_done) ctl_d.state = ST_STOP;
            ST_STOP:  if (!start_n) ctl_d.state = ST_RUN;
            ST_RUN: begin
                if (start_n)    ctl_d.state = ST_STOP;
                else if (trip)  ctl_d.state = ST_FAULT;
                else if (decel) ctl_d.state = ST_DECEL;
            end
            ST_DECEL: begin
                if (start_n)     ctl_d.state = ST_STOP;
                else if (!decel) ctl_d.state = ST_RUN;
            end
            ST_FAULT: if (start_n) ctl_d.state = ST_STOP;
            default:  ctl_d.state = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state     <= ST_RESET;
            ctl_q.brake_rev <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign drive_en     = (ctl_q.state == ST_RUN) || (ctl_q.state == ST_DECEL);
    assign lowside_kill = (ctl_q.state == ST_RESET) || (ctl_q.state == ST_FAULT);
    assign power_save   = (ctl_q.state == ST_RESET) || (ctl_q.state == ST_STOP);
    assign brake_rev    = ctl_q.brake_rev;
    assign clk_lost     = lost;

    // R3
    save_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(power_save && drive_en));
    // R5
    kill_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(lowside_kill && drive_en));
    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_FAULT && !start_n) |=> ctl_q.state == ST_FAULT);
    // R8
    decel_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_DECEL) |-> !trip);
    // R2
    stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_n && !in_reset) |=> ctl_q.state == ST_STOP);
endmodule

// File: tb/sim_rotor_guard.sv
module sim_rotor_guard;
    localparam int POR = 16, TRIP = 120, CT = 30;
    localparam int S_RESET = 0, S_STOP = 1, S_RUN = 2, S_DECEL = 3, S_FAULT = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_n = 1'b1, coast_sel = 1'b1, locked = 1'b1, decel = 1'b0, ref_edge = 1'b0;
    logic drive_en, lowside_kill, brake_rev, power_save, clk_lost;
    bit   ref_on = 1'b0, cmp_on = 1'b0, done = 1'b0;
    int   ref_per = 10, ref_cnt = 0, errors = 0, checks = 0;

    always #5 clk = ~clk;

    rotor_guard #(.POR_CYCLES(POR), .TRIP_CYCLES(TRIP), .CLK_TIMEOUT(CT)) u0 (
        .clk(clk), .rst_n(rst_n), .start_n(start_n), .coast_sel(coast_sel),
        .locked(locked), .ref_edge(ref_edge), .decel(decel),
        .drive_en(drive_en), .lowside_kill(lowside_kill), .brake_rev(brake_rev),
        .power_save(power_save), .clk_lost(clk_lost));

    // cycle model built from the requirements
    int m_state, m_pcnt, m_ucnt, m_wcnt;
    bit m_lost, m_brake;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = S_RESET; m_pcnt = 0; m_ucnt = 0; m_wcnt = 0; m_lost = 0; m_brake = 0;
        end else begin
            bit bad, trip; int ns;
            bad  = !locked || m_lost;
            trip = (m_state == S_RUN) && bad && (m_ucnt == TRIP - 1);
            ns = m_state;
            case (m_state)
                S_RESET: if (m_pcnt == POR) ns = S_STOP;
                S_STOP:  if (!start_n) ns = S_RUN;
                S_RUN:   if (start_n) ns = S_STOP; else if (trip) ns = S_FAULT;
                         else if (decel) ns = S_DECEL;
                S_DECEL: if (start_n) ns = S_STOP; else if (!decel) ns = S_RUN;
                default: if (start_n) ns = S_STOP;
            endcase
            m_ucnt  = ((m_state == S_RUN) && bad && !trip) ? m_ucnt + 1 : 0;
            m_brake = (m_state == S_RESET) ? 1'b0 : !coast_sel;
            if (m_state == S_RESET || ref_edge) begin m_wcnt = 0; m_lost = 0; end
            else if (m_wcnt == CT - 1) m_lost = 1;
            else m_wcnt++;
            if (m_pcnt != POR) m_pcnt++;
            m_state = ns;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference edge generator
    always @(negedge clk) begin
        if (ref_on && ref_cnt >= ref_per - 1) begin ref_edge <= 1'b1; ref_cnt <= 0; end
        else begin ref_edge <= 1'b0; ref_cnt <= ref_cnt + 1; end
    end

    // per-cycle comparison against the model
    always @(negedge clk) if (cmp_on) begin
        bit e_drv, e_kill, e_ps;
        e_drv  = (m_state == S_RUN) || (m_state == S_DECEL);
        e_kill = (m_state == S_RESET) || (m_state == S_FAULT);
        e_ps   = (m_state == S_RESET) || (m_state == S_STOP);
        chk(drive_en == e_drv, "R5 drive_en", drive_en, e_drv);
        chk(lowside_kill == e_kill, "R5 lowside_kill", lowside_kill, e_kill);
        chk(power_save == e_ps, "R3 power_save", power_save, e_ps);
        chk(brake_rev == m_brake, "R4 brake_rev", brake_rev, m_brake);
        chk(clk_lost == m_lost, "R9 clk_lost", clk_lost, m_lost);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        cyc(POR - 4);
        // R1 reset phase outputs
        chk(lowside_kill && power_save && !drive_en && !brake_rev, "R1 reset outputs",
            {drive_en, lowside_kill, power_save, brake_rev}, 4'b0110);
        cyc(6);
        chk(power_save && !lowside_kill, "R1 stop after por", lowside_kill, 0);
        ref_on = 1'b1;
        start_n = 1'b0;          // R2 start request
        cyc(2);
        chk(drive_en && !power_save, "R2 run entered", drive_en, 1);
        coast_sel = 1'b0; cyc(2);
        chk(brake_rev == 1'b1, "R4 reverse select", brake_rev, 1);
        coast_sel = 1'b1;
        locked = 1'b0; cyc(TRIP - 20); locked = 1'b1; cyc(3);
        locked = 1'b0; cyc(TRIP - 20); locked = 1'b1; cyc(3);
        chk(drive_en == 1'b1, "R6 short bursts no trip", drive_en, 1);
        locked = 1'b0; cyc(TRIP + 5);
        chk(lowside_kill && !drive_en, "R5 long burst trips", lowside_kill, 1);
        locked = 1'b1; cyc(40);
        chk(lowside_kill == 1'b1, "R7 fault survives relock", lowside_kill, 1);
        start_n = 1'b1; cyc(2);
        chk(power_save && !lowside_kill, "R7 stop clears fault", lowside_kill, 0);
        start_n = 1'b0; cyc(3);
        decel = 1'b1; locked = 1'b0; cyc(3 * TRIP);
        chk(drive_en && !lowside_kill, "R8 decel suppresses timer", drive_en, 1);
        locked = 1'b1; decel = 1'b0; cyc(5);
        chk(drive_en == 1'b1, "R8 back to run", drive_en, 1);
        ref_on = 1'b0; cyc(CT + 12);
        chk(clk_lost == 1'b1, "R9 clock loss flagged", clk_lost, 1);
        cyc(TRIP + 5);
        chk(lowside_kill == 1'b1, "R10 clock loss trips", lowside_kill, 1);
        ref_on = 1'b1; cyc(ref_per + 3);
        chk(clk_lost == 1'b0, "R9 clock loss cleared", clk_lost, 0);
        start_n = 1'b1; cyc(4);

        // random phase
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if ($urandom_range(299) == 0) start_n = ~start_n;
            if ($urandom_range(59) == 0)  locked  = ~locked;
            if ($urandom_range(399) == 0) decel   = ~decel;
            if ($urandom_range(49) == 0)  coast_sel = $urandom_range(1);
            if ($urandom_range(499) == 0) ref_on  = ~ref_on;
            if ($urandom_range(999) == 0) ref_per = 2 + $urandom_range(40);
        end
        cmp_on = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule